// File: doc/BRIEF.md
# Low-Speed USB Bus Idle, Reset and Wake Monitor

This block watches the line state of a low-speed USB port and turns it into three one-cycle events for the device logic: a bus reset, a suspend request after a long idle spell, and a wake-up seen on the bus while the device sleeps. The line state arrives as a two-bit code. It passes through a two-flop synchronizer before any detector sees it.

The block also holds the device address. Software writes the address, and a detected bus reset clears it. Software drives two control bits. The sleep bit gates the serial engine clock enable. The sleep bit and the wake-drive bit together request that the port drive a K state upstream. The analog transceiver and the regulator are not part of this block.

Top module: `usb_susp_mon`

## Requirements
- R1: After reset, all event pulses and `drive_k_o` are 0, `eng_clk_en_o` is 1 and `dev_addr_o` is 0.
- R2: `susp_req_o` pulses for one cycle once the synchronized line has held J (code 2'b01) with no transition for IDLE_CLKS consecutive cycles. It fires only once per idle spell.
- R3: Any synchronized state other than J, or any change of state, restarts the idle count. A K (2'b10) glitch therefore postpones the suspend request by a full IDLE_CLKS.
- R4: `bus_rst_o` pulses for one cycle when the synchronized line has been SE0 (2'b00) for RST_CLKS consecutive cycles. An SE0 spell one cycle shorter gives no pulse.
- R5: When `addr_we_i` is 1 on a clock edge, `addr_wdata_i` is loaded into `dev_addr_o`.
- R6: The bus reset clears `dev_addr_o` on the same edge that raises `bus_rst_o`. It wins over an address write on that edge.
- R7: `eng_clk_en_o` goes to 0 one cycle after `susp_i` rises and returns to 1 one cycle after it falls.
- R8: `resume_o` pulses once at the start of bus activity (non-J state or transition) only while `susp_i` is 1 and the block is not itself driving K. With `susp_i` at 0, activity gives no pulse.
- R9: `drive_k_o` is 1 one cycle after `susp_i` and `rsmo_i` are both 1. It is held while both stay 1 and drops one cycle after either is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 6 MHz block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 2 | Raw line state: 00 SE0, 01 J, 10 K, 11 invalid (treated as activity) |
| susp_i | input | 1 | Software sleep bit |
| rsmo_i | input | 1 | Software wake-drive bit |
| addr_we_i | input | 1 | Device address write strobe |
| addr_wdata_i | input | AW | Device address write data |
| bus_rst_o | output | 1 | One-cycle bus reset event |
| susp_req_o | output | 1 | One-cycle idle suspend request event |
| resume_o | output | 1 | One-cycle wake-up event while asleep |
| eng_clk_en_o | output | 1 | Serial engine clock enable |
| drive_k_o | output | 1 | Request to drive K upstream |
| dev_addr_o | output | AW | Current device address |

## Verification
A software address write and the bus-reset clear can land on the same clock edge. The bench holds the write strobe high with a non-zero address across a full SE0 spell, so the last write coincides with the edge on which the reset is detected. It then expects `bus_rst_o` high and the address at zero on that very cycle. A second pair is a K on the line while the port is asleep and driving K itself. There the resume detector must stay silent, and the scoreboard treats any resume pulse with nothing queued as a mismatch.

// File: rtl/usb_susp_mon.sv
module usb_susp_mon #(
  parameter int IDLE_CLKS = 18000,
  parameter int RST_CLKS  = 15,
  parameter int AW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    line_i,
  input  logic          susp_i,
  input  logic          rsmo_i,
  input  logic          addr_we_i,
  input  logic [AW-1:0] addr_wdata_i,
  output logic          bus_rst_o,
  output logic          susp_req_o,
  output logic          resume_o,
  output logic          eng_clk_en_o,
  output logic          drive_k_o,
  output logic [AW-1:0] dev_addr_o
);

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam int IW = $clog2(IDLE_CLKS + 1);
  localparam int RW = $clog2(RST_CLKS + 1);
  localparam logic [IW-1:0] IDLE_MAX  = IW'(IDLE_CLKS);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CLKS - 1);
  localparam logic [RW-1:0] RST_MAX   = RW'(RST_CLKS);
  localparam logic [RW-1:0] RST_LAST  = RW'(RST_CLKS - 1);

  logic [1:0]    sync1, ls, ls_prev;
  logic [IW-1:0] idle_cnt;
  logic [RW-1:0] se0_cnt;
  logic          act_prev;

  wire activity  = (ls != LS_J) || (ls != ls_prev);
  wire is_se0    = (ls == LS_SE0);
  wire idle_hit  = !activity && (idle_cnt == IDLE_LAST);
  wire reset_hit = is_se0 && (se0_cnt == RST_LAST);
  wire wake_hit  = susp_i && !drive_k_o && activity && !act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= LS_J;
      ls      <= LS_J;
      ls_prev <= LS_J;
    end else begin
      sync1   <= line_i;
      ls      <= sync1;
      ls_prev <= ls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idle_cnt <= '0;
    else if (activity)         idle_cnt <= '0;
    else if (idle_cnt != IDLE_MAX) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               se0_cnt <= '0;
    else if (!is_se0)         se0_cnt <= '0;
    else if (se0_cnt != RST_MAX) se0_cnt <= se0_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev     <= 1'b0;
      bus_rst_o    <= 1'b0;
      susp_req_o   <= 1'b0;
      resume_o     <= 1'b0;
      eng_clk_en_o <= 1'b1;
      drive_k_o    <= 1'b0;
    end else begin
      act_prev     <= activity;
      bus_rst_o    <= reset_hit;
      susp_req_o   <= idle_hit;
      resume_o     <= wake_hit;
      eng_clk_en_o <= !susp_i;
      drive_k_o    <= susp_i && rsmo_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dev_addr_o <= '0;
    else if (reset_hit) dev_addr_o <= '0;
    else if (addr_we_i) dev_addr_o <= addr_wdata_i;
  end

endmodule

// File: rtl/usb_susp_mon_chk.sv
module usb_susp_mon_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          susp_i,
  input logic          rsmo_i,
  input logic          bus_rst_o,
  input logic          susp_req_o,
  input logic          resume_o,
  input logic          eng_clk_en_o,
  input logic          drive_k_o,
  input logic [AW-1:0] dev_addr_o
);

  a_r2_single_susp_req: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req_o |=> !susp_req_o);

  a_r4_single_bus_rst: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_o |=> !bus_rst_o);

  a_r6_rst_clears_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_o |-> dev_addr_o == '0);

  a_r7_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    susp_i |=> !eng_clk_en_o);

  a_r8_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> $past(susp_i));

  a_r8_no_wake_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> !$past(drive_k_o));

  a_r9_drive_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_i && rsmo_i) |=> drive_k_o);

  a_r9_drive_released: assert property (@(posedge clk) disable iff (!rst_n)
    !(susp_i && rsmo_i) |=> !drive_k_o);

endmodule

bind usb_susp_mon usb_susp_mon_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_usb_susp_mon.sv
module sim_usb_susp_mon;

  localparam int IDLE = 200;
  localparam int RSTC = 15;
  localparam int AW   = 7;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;
  localparam logic [1:0] EV_SUSP = 2'd1, EV_RST = 2'd2, EV_RSM = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] line_i = J;
  logic susp_i = 1'b0, rsmo_i = 1'b0, addr_we_i = 1'b0;
  logic [AW-1:0] addr_wdata_i = '0;
  logic bus_rst_o, susp_req_o, resume_o, eng_clk_en_o, drive_k_o;
  logic [AW-1:0] dev_addr_o;

  int compared = 0, mismatched = 0;
  logic [1:0] exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_susp_mon #(.IDLE_CLKS(IDLE), .RST_CLKS(RSTC), .AW(AW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic see(input logic [1:0] kind, input string req);
    compared++;
    if (exp_q.size() == 0) begin
      mismatched++;
      $display("FAIL %s actual=event%0d expected=none", req, kind);
    end else begin
      logic [1:0] e = exp_q.pop_front();
      if (e != kind) begin
        mismatched++;
        $display("FAIL %s actual=event%0d expected=event%0d", req, kind, e);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_rst_o)  see(EV_RST, "R4");
    if (susp_req_o) see(EV_SUSP, "R2");
    if (resume_o)   see(EV_RSM, "R8");
  end

  task automatic idle_period();
    exp_q.push_back(EV_SUSP);
    repeat (IDLE + 20) @(negedge clk);
  endtask

  task automatic k_burst(input int n);
    line_i = K;
    repeat (n) @(negedge clk);
    line_i = J;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 bus_rst", bus_rst_o, 0);
    chk("R1 susp_req", susp_req_o, 0);
    chk("R1 resume", resume_o, 0);
    chk("R1 clk_en", eng_clk_en_o, 1);
    chk("R1 drive_k", drive_k_o, 0);
    chk("R1 addr", dev_addr_o, 0);
    rst_n = 1'b1;

    // R2: first idle spell after reset, then long J with no second request
    idle_period();
    repeat (IDLE * 2) @(negedge clk);

    // R3: glitches inside the window postpone the request
    k_burst(3);
    repeat (IDLE - 60) @(negedge clk);
    k_burst(2);
    repeat (IDLE - 60) @(negedge clk);
    chk("R3 pending", exp_q.size(), 0);
    idle_period();

    // R5: address write
    addr_we_i = 1'b1; addr_wdata_i = 7'h2A;
    @(negedge clk);
    addr_we_i = 1'b0;
    chk("R5 addr", dev_addr_o, 'h2A);

    // R4: SE0 one cycle short of the limit gives nothing
    line_i = SE0;
    repeat (RSTC - 1) @(negedge clk);
    line_i = J;
    repeat (20) @(negedge clk);
    chk("R4 short addr kept", dev_addr_o, 'h2A);

    // R4/R6: full SE0 spell with a write on every edge, reset wins
    exp_q.push_back(EV_RST);
    line_i = SE0; addr_we_i = 1'b1; addr_wdata_i = 7'h55;
    for (int i = 1; i <= RSTC + 2; i++) begin
      @(negedge clk);
      if (i == RSTC) line_i = J;
      if (i == RSTC + 1) chk("R6 write before reset", dev_addr_o, 'h55);
      if (i == RSTC + 2) begin
        chk("R4 pulse cycle", bus_rst_o, 1);
        chk("R6 addr cleared", dev_addr_o, 0);
      end
    end
    addr_we_i = 1'b0;
    @(negedge clk);
    chk("R6 addr stays clear", dev_addr_o, 0);
    idle_period();

    // R7/R8: sleep, then bus wake
    susp_i = 1'b1;
    @(negedge clk);
    chk("R7 clk_en off", eng_clk_en_o, 0);
    exp_q.push_back(EV_RSM);
    k_burst(5);
    chk("R8 wake seen", exp_q.size(), 0);
    idle_period();
    susp_i = 1'b0;
    @(negedge clk);
    chk("R7 clk_en on", eng_clk_en_o, 1);

    // R8: awake, activity is not a wake event
    k_burst(5);
    idle_period();

    // R9: drive request needs both bits
    susp_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 sleep only", drive_k_o, 0);
    rsmo_i = 1'b1;
    @(negedge clk);
    chk("R9 both set", drive_k_o, 1);
    k_burst(5);
    chk("R9 held", drive_k_o, 1);
    rsmo_i = 1'b0;
    @(negedge clk);
    chk("R9 released", drive_k_o, 0);
    susp_i = 1'b0; rsmo_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 wake bit only", drive_k_o, 0);
    rsmo_i = 1'b0;
    idle_period();

    repeat (10) @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule